// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block turns the output clock of an external two-ratio prescaler into one feedback pulse per division cycle for a phase detector. Each cycle lasts N clocks of its input. The swallow count A sets how many of those clocks run with the prescaler at its larger ratio, P+1. The rest run at P. The loop therefore divides the oscillator by N·P+A. The block steers the prescaler through a single modulus-control output: low selects P+1 and high selects P.

The divide values arrive as parallel words along with a load strobe. A load can act at once, which restarts the cycle. It can also be held back until the counters next wrap, so the feedback phase is not disturbed. Mode inputs select single-ratio operation, standby, and whether the modulus output changes on the rising or the falling edge of the input clock. The mode inputs are registered, so each takes effect one clock after it is sampled. Any value outside the legal range is clamped, and a sticky flag records that this happened.

Top module: `swallow_divider`

## Requirements
- R1: In dual mode with the rising-edge update, a cycle has N input clocks, counted 0 to N-1. During the clock at count k, mod_ctl is 0 while k < A and 1 once k >= A.
- R2: With the prescaler dividing by P while mod_ctl=1 and by P+1 while mod_ctl=0, one full cycle spans N·P+A oscillator periods.
- R3: When A=0, mod_ctl is 1 for every count of the cycle.
- R4: While single mode (dual_mode=0) or standby is registered, mod_ctl is 0. Standby also holds the count at 0, so div_pulse stays low.
- R5: With sync_load=1, a strobed value is held back. It becomes active from the first count after the next wrap. If the strobe lands on the wrap clock itself, the value governs the cycle that follows.
- R6: With sync_load=0, a strobed value is active from the next clock, and the count restarts at 0.
- R7: When fall_edge_sel=1 is registered, mod_ctl takes the value that the rising-edge mode would show, but half an input clock later, at the falling edge.
- R8: div_pulse is high for exactly the one input clock at count N-1.
- R9: A strobed N is clamped to the range 3..16380. If A >= the clamped N, A becomes N-1. Either correction sets cfg_err, and only reset clears it.
- R10: After a synchronous reset, mod_ctl, div_pulse and cfg_err are 0, the active values are N=3 and A=0, and all modes are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, which drives all counting |
| rst | input | 1 | Synchronous active-high reset |
| n_cfg | input | 14 | Requested main count N |
| a_cfg | input | 7 | Requested swallow count A |
| load_stb | input | 1 | One-clock strobe that accepts n_cfg and a_cfg |
| sync_load | input | 1 | 1: defer the load to the next wrap; 0: apply it at once and restart |
| dual_mode | input | 1 | 1: two-ratio operation; 0: single ratio, modulus held low |
| fall_edge_sel | input | 1 | 1: modulus output changes on the falling edge |
| standby | input | 1 | Stops counting and holds the modulus output low |
| mod_ctl | output | 1 | Prescaler ratio select (1 = P, 0 = P+1) |
| div_pulse | output | 1 | One-clock pulse at the last count of each cycle |
| cfg_err | output | 1 | Sticky flag: a strobed value was clamped |

## Verification
The assertions rely on a few things about the inputs. The load strobe and all mode inputs must be stable around the rising edge. Reset must be high from time zero. The clamping ensures that the active values always satisfy 3 <= N and A < N. The stimulus changes every input just after a rising edge. It strobes legal values, out-of-range values and A >= N, and it toggles the modes only while the clock runs. A behavioural model of the prescaler sums P or P+1 for each clock to measure the ratio, and it counts only cycles in which no load, standby or mode change intervened.

// File: rtl/swl_pkg.sv
package swl_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } swl_edge_e;

    typedef struct packed {
        logic      dual;
        logic      stby;
        swl_edge_e edge_sel;
    } swl_mode_t;

    function automatic int clamp_range(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/swl_cfg.sv
module swl_cfg
    import swl_pkg::*;
#(
    parameter int N_W   = 14,
    parameter int A_W   = 7,
    parameter int N_MIN = 3,
    parameter int N_MAX = 16380
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_stb,
    input  logic           sync_load,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    input  logic           dual_in,
    input  logic           standby_in,
    input  logic           fall_in,
    input  logic           wrap,
    output logic [N_W-1:0] n_act,
    output logic [A_W-1:0] a_act,
    output swl_mode_t      mode,
    output logic           restart,
    output logic           err
);
    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } div_cfg_t;

    div_cfg_t fresh;
    div_cfg_t pend_q;
    div_cfg_t act_q;
    logic     pend_v;
    logic     hit;

    // Clamp the requested words into the legal divide range
    always_comb begin
        fresh.n = N_W'(clamp_range(int'(n_in), N_MIN, N_MAX));
        if (int'(a_in) >= int'(fresh.n))
            fresh.a = A_W'(int'(fresh.n) - 1);
        else
            fresh.a = a_in;
        hit = (int'(n_in) < N_MIN) || (int'(n_in) > N_MAX) ||
              (int'(a_in) >= int'(fresh.n));
    end

    assign restart = load_stb && !sync_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q.n       <= N_W'(N_MIN);
            act_q.a       <= '0;
            pend_q        <= '0;
            pend_v        <= 1'b0;
            err           <= 1'b0;
            mode.dual     <= 1'b0;
            mode.stby     <= 1'b0;
            mode.edge_sel <= EDGE_RISE;
        end else begin
            mode.dual     <= dual_in;
            mode.stby     <= standby_in;
            mode.edge_sel <= fall_in ? EDGE_FALL : EDGE_RISE;
            if (load_stb && hit)
                err <= 1'b1;
            if (restart) begin
                act_q  <= fresh;
                pend_v <= 1'b0;
            end else if (wrap && load_stb) begin
                act_q  <= fresh;
                pend_v <= 1'b0;
            end else if (wrap && pend_v) begin
                act_q  <= pend_q;
                pend_v <= 1'b0;
            end else if (load_stb) begin
                pend_q <= fresh;
                pend_v <= 1'b1;
            end
        end
    end

    assign n_act = act_q.n;
    assign a_act = act_q.a;

    // R9: active values always legal
    a_r9_n_legal: assert property (@(posedge clk) disable iff (rst)
        (int'(n_act) >= N_MIN) && (int'(n_act) <= N_MAX) && (int'(a_act) < int'(n_act)));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5: without an immediate load or a wrap, active values hold
    a_r5_defer_hold: assert property (@(posedge clk) disable iff (rst)
        (!restart && !wrap) |=> ($stable(n_act) && $stable(a_act)));

endmodule

// File: rtl/swl_count.sv
module swl_count #(
    parameter int N_W = 14,
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_act,
    input  logic [A_W-1:0] a_act,
    input  logic           dual,
    input  logic           stby,
    input  logic           restart,
    output logic           wrap,
    output logic           tgt
);
    logic [N_W-1:0] cnt_q;

    assign wrap = !stby && (cnt_q == n_act - N_W'(1));
    assign tgt  = dual && !stby && (cnt_q >= N_W'(a_act));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (stby || restart || wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + N_W'(1);
    end

    // R1: the count never reaches N
    a_r1_cnt_below_n: assert property (@(posedge clk) disable iff (rst)
        cnt_q < n_act);

    // R4: standby parks the count at zero
    a_r4_stby_hold: assert property (@(posedge clk) disable iff (rst)
        stby |=> (cnt_q == '0));

    // R1: modulus falls only at a cycle start, a restart or a mode change
    a_r1_low_at_start: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt) |-> ($past(wrap) || $past(restart) ||
                        (dual != $past(dual)) || (stby != $past(stby))));

endmodule

// File: rtl/swl_mod_out.sv
module swl_mod_out
    import swl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tgt,
    input  swl_edge_e edge_sel,
    output logic      mod_ctl
);
    logic mod_neg_q;

    always_ff @(negedge clk) begin
        if (rst)
            mod_neg_q <= 1'b0;
        else
            mod_neg_q <= tgt;
    end

    assign mod_ctl = (edge_sel == EDGE_FALL) ? mod_neg_q : tgt;

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swl_pkg::*;
#(
    parameter int N_W   = 14,
    parameter int A_W   = 7,
    parameter int N_MIN = 3,
    parameter int N_MAX = 16380
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_cfg,
    input  logic [A_W-1:0] a_cfg,
    input  logic           load_stb,
    input  logic           sync_load,
    input  logic           dual_mode,
    input  logic           fall_edge_sel,
    input  logic           standby,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic           cfg_err
);
    logic [N_W-1:0] n_act;
    logic [A_W-1:0] a_act;
    swl_mode_t      mode;
    logic           restart;
    logic           wrap;
    logic           tgt;

    swl_cfg #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .load_stb   (load_stb),
        .sync_load  (sync_load),
        .n_in       (n_cfg),
        .a_in       (a_cfg),
        .dual_in    (dual_mode),
        .standby_in (standby),
        .fall_in    (fall_edge_sel),
        .wrap       (wrap),
        .n_act      (n_act),
        .a_act      (a_act),
        .mode       (mode),
        .restart    (restart),
        .err        (cfg_err)
    );

    swl_count #(.N_W(N_W), .A_W(A_W)) count_i (
        .clk     (clk),
        .rst     (rst),
        .n_act   (n_act),
        .a_act   (a_act),
        .dual    (mode.dual),
        .stby    (mode.stby),
        .restart (restart),
        .wrap    (wrap),
        .tgt     (tgt)
    );

    swl_mod_out mod_i (
        .clk      (clk),
        .rst      (rst),
        .tgt      (tgt),
        .edge_sel (mode.edge_sel),
        .mod_ctl  (mod_ctl)
    );

    assign div_pulse = wrap;

    // R8: feedback pulse is one clock wide
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

endmodule

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;
    localparam int P = 8;
    localparam int WD_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] n_cfg;
    logic [6:0]  a_cfg;
    logic        load_stb, sync_load, dual_mode, fall_edge_sel, standby;
    logic        mod_ctl, div_pulse, cfg_err;

    always #5 clk = ~clk;

    swallow_divider dut_i (
        .clk(clk), .rst(rst), .n_cfg(n_cfg), .a_cfg(a_cfg),
        .load_stb(load_stb), .sync_load(sync_load), .dual_mode(dual_mode),
        .fall_edge_sel(fall_edge_sel), .standby(standby),
        .mod_ctl(mod_ctl), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R10";
    bit    done  = 0;

    // behavioural reference state
    int m_cnt, m_n, m_a, m_pn, m_pa, acc;
    bit m_pend, m_err, m_dual, m_stby, m_edge, m_negv, m_clean;

    task automatic chk(bit ok, string tag, int got, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (phase %s) t=%0t: got %0d expected %0d", tag, phase, $time, got, exp);
        end
    endtask

    function automatic bit m_tgt();
        return m_dual && !m_stby && (m_cnt >= m_a);
    endfunction

    function automatic bit m_pulse();
        return !m_stby && (m_cnt == m_n - 1);
    endfunction

    function automatic string mod_tag();
        if (m_stby || !m_dual) return "R4";
        if (m_edge) return "R7";
        if (m_a == 0) return "R3";
        return "R1";
    endfunction

    task automatic compare_all();
        bit e;
        e = m_edge ? m_negv : m_tgt();
        chk(mod_ctl == e, mod_tag(), int'(mod_ctl), int'(e));
        chk(div_pulse == m_pulse(), "R8", int'(div_pulse), int'(m_pulse()));
        chk(cfg_err == m_err, "R9", int'(cfg_err), int'(m_err));
    endtask

    always @(posedge clk) begin : mdl
        bit wrap, restart, hit;
        int cn, ca;
        if (rst) begin
            m_cnt = 0; m_n = 3; m_a = 0; m_pn = 3; m_pa = 0; m_pend = 0; m_err = 0;
            m_dual = 0; m_stby = 0; m_edge = 0; m_clean = 0; acc = 0;
        end else begin
            wrap    = !m_stby && (m_cnt == m_n - 1);
            restart = load_stb && !sync_load;
            cn = int'(n_cfg);
            if (cn < 3) cn = 3;
            if (cn > 16380) cn = 16380;
            ca  = (int'(a_cfg) >= cn) ? cn - 1 : int'(a_cfg);
            hit = (int'(n_cfg) < 3) || (int'(n_cfg) > 16380) || (int'(a_cfg) >= cn);
            if (restart) begin
                m_n = cn; m_a = ca; m_pend = 0;
            end else if (wrap && load_stb) begin
                m_n = cn; m_a = ca; m_pend = 0;
            end else if (wrap && m_pend) begin
                m_n = m_pn; m_a = m_pa; m_pend = 0;
            end else if (load_stb) begin
                m_pn = cn; m_pa = ca; m_pend = 1;
            end
            if (load_stb && hit) m_err = 1;
            if (m_stby || restart || wrap) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (wrap) m_clean = 1;
            if (restart) m_clean = 0;
            m_dual = dual_mode; m_stby = standby; m_edge = fall_edge_sel;
        end
        #4;
        compare_all();
    end

    always @(negedge clk) begin
        m_negv = rst ? 1'b0 : m_tgt();
        #4;
        compare_all();
        if (!rst) begin
            if (!(m_dual && !m_stby && !m_edge)) m_clean = 0;
            acc = acc + (mod_ctl ? P : P + 1);
            if (m_pulse()) begin
                if (m_clean) chk(acc == m_n * P + m_a, "R2", acc, m_n * P + m_a);
                acc = 0;
            end
        end
    end

    task automatic run(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic load(int n, int a, bit sy);
        @(posedge clk); #1;
        n_cfg = 14'(n); a_cfg = 7'(a); sync_load = sy; load_stb = 1'b1;
        @(posedge clk); #1;
        load_stb = 1'b0;
    endtask

    initial begin
        rst = 1'b1; n_cfg = 14'd3; a_cfg = 7'd0; load_stb = 1'b0; sync_load = 1'b0;
        dual_mode = 1'b0; fall_edge_sel = 1'b0; standby = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk(mod_ctl == 1'b0, "R10 mod_ctl", int'(mod_ctl), 0);
        chk(div_pulse == 1'b0, "R10 div_pulse", int'(div_pulse), 0);
        chk(cfg_err == 1'b0, "R10 cfg_err", int'(cfg_err), 0);
        run(10);

        phase = "R6"; dual_mode = 1'b1;
        load(10, 3, 0); run(45);
        load(4, 2, 0); run(20);

        phase = "R3";
        load(5, 0, 0); run(25);

        phase = "R7"; fall_edge_sel = 1'b1;
        load(7, 2, 0); run(30);
        fall_edge_sel = 1'b0; run(20);

        phase = "R5";
        load(12, 5, 1); run(40);
        load(6, 1, 1); run(30);

        phase = "R4"; dual_mode = 1'b0; run(20);
        dual_mode = 1'b1; standby = 1'b1; run(20);
        load(9, 4, 1); run(10);
        standby = 1'b0; run(40);

        phase = "R9";
        load(1, 0, 0); run(15);
        load(5, 9, 0); run(20);
        load(16383, 100, 0); run(16500);
        load(10, 3, 0); run(30);
        chk(cfg_err == 1'b1, "R9 sticky", int'(cfg_err), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WATCHDOG", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule